// File: doc/BRIEF.md
# Multi-Lane Serial Audio Receiver

This block receives PCM audio as a slave. It never drives a clock. It takes a bit clock, a frame clock and several serial data lines that share them, and it recovers two channels per line: one while the frame clock is low and one while it is high. The bit clock runs at 64 times the sample rate, so each channel has a 32-bit slot. Samples arrive most significant bit first in two's complement.

A two-bit format code selects where the word sits in its slot: I2S, left-justified or right-justified. A two-bit length code selects 16, 20 or 24-bit words. Both codes are latched only at the start of a frame. All external inputs are resynchronised to the block clock. The bit clock must be slow enough that every high and every low phase lasts at least two block clock cycles.

For each slot and each lane, the block emits the recovered word. The word is left-aligned in 24 bits with its unused low bits cleared, then sign-extended to the output width. It comes with a channel index and a one-cycle valid strobe.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, `sampleValid` stays low until the first left-slot start. A left-slot start is a bit clock rise at which the frame clock is sampled low after it was sampled high at the previous rise. Slots before that point produce no output.
- R2: With format code 1 (left-justified), the word's MSB is the data bit sampled at the first bit clock rise of the slot. Bit index 0 is the rise at which the new frame clock level is first seen.
- R3: With format code 0 (I2S), the MSB is the data bit at bit index 1 of the slot. The following bits of the word come at the following indices.
- R4: With format code 2 (right-justified), the LSB is the data bit at bit index 31, the last of the slot. The MSB is at index 32 minus the word length.
- R5: Length code 0 selects 16 bits, code 1 selects 20 bits, and codes 2 and 3 select 24 bits. Format code 3 behaves as I2S (code 0).
- R6: The output word holds the received bits in positions 23 down to 24 minus the length, with zeros below. Every position above bit 23 copies bit 23.
- R7: The channel index of lane k is 2k while the frame clock is low (left) and 2k+1 while it is high (right).
- R8: Data bits outside the word window of a slot have no effect on the output.
- R9: Format and length codes are sampled only at a left-slot start. A change at any other time affects neither the rest of the current frame nor its right slot.
- R10: Each lane raises `sampleValid` for exactly one block clock cycle per slot. All lanes raise it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; must be at least 4 times faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bitClk | input | 1 | Serial bit clock (64 per frame); data sampled on its rise |
| frameClk | input | 1 | Frame clock; low = left slot, high = right slot |
| serialIn | input | LANES | One serial data line per lane |
| cfgFormat | input | 2 | Framing code: 0 I2S, 1 left-justified, 2 right-justified, 3 as 0 |
| cfgWordLen | input | 2 | Length code: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| sampleValid | output | LANES | One-cycle strobe per lane when a word is ready |
| sampleChan | output | LANES*CHAN_W | Channel index per lane |
| sampleData | output | LANES*OUT_W | Left-aligned, sign-extended word per lane |

## Verification
The bench builds the block with four lanes and an output width of 28. With that width, the sign copies above bit 23 show at the ports. All four lanes also carry independent random data, so a crossed lane or a wrong channel index is caught. The slot width stays at 32, so every word window lands on real slot positions. Filler bits outside the windows are random, which brings R8 within reach in every frame. The length and format codes 3 appear in both the directed and the random frames.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  localparam int MAX_WORD = 24;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN20 = 2'd1,
    LEN24 = 2'd2
  } len_e;

  // Strobes from the slot control to every lane datapath
  typedef struct packed {
    logic shift;
    logic capture;
    logic right;
    len_e len;
  } strobe_t;

  function automatic fmt_e fmtDecode(input logic [1:0] code);
    case (code)
      2'd1:    return FMT_LEFT;
      2'd2:    return FMT_RIGHT;
      default: return FMT_I2S;
    endcase
  endfunction

  function automatic len_e lenDecode(input logic [1:0] code);
    case (code)
      2'd0:    return LEN16;
      2'd1:    return LEN20;
      default: return LEN24;
    endcase
  endfunction

  function automatic logic [4:0] lenBits(input len_e len);
    case (len)
      LEN16:   return 5'd16;
      LEN20:   return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sai_rx_ctrl.sv
module sai_rx_ctrl
  import sai_rx_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitClkS,
  input  logic       frameClkS,
  input  logic [1:0] cfgFormat,
  input  logic [1:0] cfgWordLen,
  output strobe_t    strb
);

  localparam int CNT_W = $clog2(SLOT_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] SLOT_LEN = CNT_W'(SLOT_BITS);

  logic             bitClkQ;
  logic             frameLast;
  logic [CNT_W-1:0] slotCnt;
  logic             framed;
  fmt_e             actFmt;
  len_e             actLen;

  logic             bitRise;
  logic             slotEdge;
  logic             leftStart;
  logic             framedEff;
  logic [CNT_W-1:0] bitIdx;
  fmt_e             effFmt;
  len_e             effLen;
  logic [CNT_W-1:0] wordBits;
  logic [CNT_W-1:0] startIdx;
  logic [CNT_W-1:0] lastIdx;
  logic             inWindow;

  // Edge detection on the resynchronised clocks
  assign bitRise   = bitClkS & ~bitClkQ;
  assign slotEdge  = bitRise & (frameClkS != frameLast);
  assign leftStart = slotEdge & ~frameClkS;
  assign framedEff = framed | leftStart;

  always_comb begin
    if (slotEdge)               bitIdx = '0;
    else if (slotCnt == CNT_MAX) bitIdx = CNT_MAX;
    else                        bitIdx = slotCnt + 1'b1;
  end

  // The configuration in force for this rise: new codes only at a left start
  assign effFmt   = leftStart ? fmtDecode(cfgFormat)  : actFmt;
  assign effLen   = leftStart ? lenDecode(cfgWordLen) : actLen;
  assign wordBits = CNT_W'(lenBits(effLen));

  always_comb begin
    case (effFmt)
      FMT_LEFT:  startIdx = '0;
      FMT_RIGHT: startIdx = SLOT_LEN - wordBits;
      default:   startIdx = CNT_W'(1);
    endcase
  end

  assign lastIdx  = startIdx + wordBits - 1'b1;
  assign inWindow = framedEff & bitRise & (bitIdx >= startIdx) & (bitIdx <= lastIdx);

  always_comb begin
    strb.shift   = inWindow;
    strb.capture = inWindow & (bitIdx == lastIdx);
    strb.right   = frameClkS;
    strb.len     = effLen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitClkQ   <= 1'b0;
      frameLast <= 1'b0;
      slotCnt   <= CNT_MAX;
      framed    <= 1'b0;
      actFmt    <= FMT_I2S;
      actLen    <= LEN24;
    end else begin
      bitClkQ <= bitClkS;
      if (bitRise) begin
        frameLast <= frameClkS;
        slotCnt   <= bitIdx;
      end
      if (leftStart) begin
        framed <= 1'b1;
        actFmt <= effFmt;
        actLen <= effLen;
      end
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !leftStart |=> ($stable(actFmt) && $stable(actLen))); // R9

  AST_NO_EARLY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!framed && !leftStart) |-> !strb.capture); // R1

  AST_SHIFT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    strb.shift |-> (bitClkS && !bitClkQ)); // R8

endmodule

// File: rtl/sai_rx_lane.sv
module sai_rx_lane
  import sai_rx_pkg::*;
#(
  parameter int OUT_W    = 24,
  parameter int CHAN_W   = 3,
  parameter int LANE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic              dataBit,
  output logic              valid,
  output logic [CHAN_W-1:0] chan,
  output logic [OUT_W-1:0]  data
);

  logic [MAX_WORD-1:0] shiftReg;
  logic [MAX_WORD-1:0] nextShift;
  logic [MAX_WORD-1:0] aligned;
  logic [MAX_WORD-1:0] wordReg;
  logic [4:0]          shiftAmt;
  len_e                wordLen;

  assign nextShift = {shiftReg[MAX_WORD-2:0], dataBit};
  assign shiftAmt  = 5'(MAX_WORD) - lenBits(strb.len);
  // Left alignment pushes stale upper bits out and clears the tail
  assign aligned   = nextShift << shiftAmt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      wordReg  <= '0;
      wordLen  <= LEN24;
      valid    <= 1'b0;
      chan     <= '0;
    end else begin
      if (strb.shift) shiftReg <= nextShift;
      valid <= strb.capture;
      if (strb.capture) begin
        wordReg <= aligned;
        wordLen <= strb.len;
        chan    <= CHAN_W'(2 * LANE_IDX + int'(strb.right));
      end
    end
  end

  if (OUT_W > MAX_WORD) begin : g_extend
    assign data = {{(OUT_W - MAX_WORD){wordReg[MAX_WORD-1]}}, wordReg};
  end else begin : g_plain
    assign data = wordReg[MAX_WORD-1 -: OUT_W];
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R10

  AST_ZERO_TAIL16: assert property (@(posedge clk) disable iff (rst)
    (valid && wordLen == LEN16) |-> (wordReg[7:0] == 8'd0)); // R6

  AST_ZERO_TAIL20: assert property (@(posedge clk) disable iff (rst)
    (valid && wordLen == LEN20) |-> (wordReg[3:0] == 4'd0)); // R6

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import sai_rx_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int OUT_W       = 24,
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CHAN_W      = $clog2(2 * LANES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bitClk,
  input  logic                     frameClk,
  input  logic [LANES-1:0]         serialIn,
  input  logic [1:0]               cfgFormat,
  input  logic [1:0]               cfgWordLen,
  output logic [LANES-1:0]         sampleValid,
  output logic [LANES*CHAN_W-1:0]  sampleChan,
  output logic [LANES*OUT_W-1:0]   sampleData
);

  localparam int SYNC_W = LANES + 2;

  logic [SYNC_W-1:0] rawIn;
  logic [SYNC_W-1:0] syncIn;
  logic              bitClkS;
  logic              frameClkS;
  logic [LANES-1:0]  dataS;
  strobe_t           strb;

  // Clocks and data share one synchroniser so they keep their alignment
  assign rawIn     = {serialIn, frameClk, bitClk};
  assign bitClkS   = syncIn[0];
  assign frameClkS = syncIn[1];
  assign dataS     = syncIn[SYNC_W-1:2];

  sai_rx_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  sai_rx_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .bitClkS    (bitClkS),
    .frameClkS  (frameClkS),
    .cfgFormat  (cfgFormat),
    .cfgWordLen (cfgWordLen),
    .strb       (strb)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sai_rx_lane #(.OUT_W(OUT_W), .CHAN_W(CHAN_W), .LANE_IDX(g)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .strb    (strb),
      .dataBit (dataS[g]),
      .valid   (sampleValid[g]),
      .chan    (sampleChan[g*CHAN_W +: CHAN_W]),
      .data    (sampleData[g*OUT_W +: OUT_W])
    );
  end

  AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (sampleValid == '0) || (sampleValid == '1)); // R10

endmodule

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;

  localparam int LANES = 4;
  localparam int OW    = 28;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitClk = 1'b0;
  logic frameClk = 1'b0;
  logic [LANES-1:0] serialIn = '0;
  logic [1:0] cfgFormat = 2'd0;
  logic [1:0] cfgWordLen = 2'd2;
  logic [LANES-1:0] sampleValid;
  logic [LANES*CW-1:0] sampleChan;
  logic [LANES*OW-1:0] sampleData;

  int checks = 0;
  int errors = 0;
  int validSeen = 0;
  bit done = 0;
  logic prevValid = 1'b0;

  logic [23:0] leftVal [LANES];
  logic [23:0] rightVal [LANES];

  logic [LANES*OW-1:0] expData [$];
  logic                expSide [$];
  string               expTag  [$];

  always #5 clk = ~clk;

  audio_serial_rx #(.LANES(LANES), .OUT_W(OW)) i_audio_serial_rx (
    .clk(clk), .rst(rst), .bitClk(bitClk), .frameClk(frameClk),
    .serialIn(serialIn), .cfgFormat(cfgFormat), .cfgWordLen(cfgWordLen),
    .sampleValid(sampleValid), .sampleChan(sampleChan), .sampleData(sampleData)
  );

  function automatic int decLen(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic int decFmt(input logic [1:0] c);
    return (c == 2'd3) ? 0 : int'(c);
  endfunction

  function automatic int firstIdx(input int f, input int l);
    return (f == 1) ? 0 : (f == 2) ? 32 - l : 1;
  endfunction

  function automatic logic [OW-1:0] expWord(input logic [23:0] v, input int l);
    logic [23:0] a;
    a = v << (24 - l);
    return {{(OW-24){a[23]}}, a};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic lr, input logic [LANES-1:0] bits);
    @(negedge clk);
    bitClk = 1'b0; frameClk = lr; serialIn = bits;
    @(negedge clk);
    @(negedge clk);
    bitClk = 1'b1;
    @(negedge clk);
  endtask

  // One slot: data fills the word window, filler is random or forced
  task automatic sendSlot(input logic side, input int f, input int l,
                          input int fill, input bit midChange,
                          input logic [1:0] nf, input logic [1:0] nl);
    int s;
    logic [LANES-1:0] b;
    s = firstIdx(f, l);
    for (int i = 0; i < 32; i++) begin
      if (midChange && i == 5) begin cfgFormat = nf; cfgWordLen = nl; end
      for (int k = 0; k < LANES; k++) begin
        if (i >= s && i < s + l)
          b[k] = side ? rightVal[k][l-1-(i-s)] : leftVal[k][l-1-(i-s)];
        else
          b[k] = (fill < 0) ? 1'($urandom) : 1'(fill);
      end
      sendBit(side, b);
    end
  endtask

  task automatic sendFrame(input logic [1:0] fc, input logic [1:0] lc, input string tag,
                           input int fill, input bit midChange,
                           input logic [1:0] nf, input logic [1:0] nl);
    int f, l;
    logic [LANES*OW-1:0] e;
    f = decFmt(fc); l = decLen(lc);
    cfgFormat = fc; cfgWordLen = lc;
    for (int k = 0; k < LANES; k++) e[k*OW +: OW] = expWord(leftVal[k], l);
    expData.push_back(e); expSide.push_back(1'b0); expTag.push_back(tag);
    for (int k = 0; k < LANES; k++) e[k*OW +: OW] = expWord(rightVal[k], l);
    expData.push_back(e); expSide.push_back(1'b1); expTag.push_back(tag);
    sendSlot(1'b0, f, l, fill, midChange, nf, nl);
    sendSlot(1'b1, f, l, fill, 1'b0, nf, nl);
  endtask

  task automatic randVals();
    for (int k = 0; k < LANES; k++) begin
      leftVal[k]  = 24'($urandom);
      rightVal[k] = 24'($urandom);
    end
  endtask

  // Monitor: compares every strobe against the bench's expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (sampleValid != '0) begin
        validSeen++;
        check("R10 lanes together", 64'(sampleValid), 64'({LANES{1'b1}}));
        check("R10 single pulse", 64'(prevValid), 64'(0));
        if (expData.size() == 0) begin
          check("R1 unexpected sample", 64'(1), 64'(0));
        end else begin
          logic [LANES*OW-1:0] e;
          logic sd;
          string t;
          e = expData.pop_front(); sd = expSide.pop_front(); t = expTag.pop_front();
          for (int k = 0; k < LANES; k++) begin
            check(t, 64'(sampleData[k*OW +: OW]), 64'(e[k*OW +: OW]));
            check("R7 channel", 64'(sampleChan[k*CW +: CW]), 64'(2 * k + int'(sd)));
          end
        end
      end
      prevValid <= sampleValid[0];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R1 valid in reset", 64'(sampleValid), 64'(0));
    rst = 1'b0;
    // Priming: left-level bits then a full right slot, none may be emitted
    for (int i = 0; i < 8; i++) sendBit(1'b0, 4'($urandom));
    for (int i = 0; i < 32; i++) sendBit(1'b1, 4'($urandom));
    repeat (6) @(negedge clk);
    check("R1 no output before frame start", 64'(validSeen), 64'(0));

    // Left-justified, 24 bit, extreme values
    leftVal  = '{24'h800001, 24'h7FFFFF, 24'h000000, 24'hFFFFFF};
    rightVal = '{24'h123456, 24'hA5A5A5, 24'h800000, 24'h000001};
    sendFrame(2'd1, 2'd2, "R2 left-justified 24", -1, 1'b0, 2'd0, 2'd0);
    // I2S 16 bit, negative words to see sign copies
    leftVal  = '{24'h008000, 24'h00FFFF, 24'h007FFF, 24'h000001};
    rightVal = '{24'h00C3A5, 24'h001234, 24'h008001, 24'h00FFFE};
    sendFrame(2'd0, 2'd0, "R3 i2s 16", -1, 1'b0, 2'd0, 2'd0);
    sendFrame(2'd0, 2'd0, "R6 sign extension 16", 1, 1'b0, 2'd0, 2'd0);
    // Right-justified 20 bit
    randVals();
    sendFrame(2'd2, 2'd1, "R4 right-justified 20", -1, 1'b0, 2'd0, 2'd0);
    randVals();
    sendFrame(2'd2, 2'd0, "R4 right-justified 16", -1, 1'b0, 2'd0, 2'd0);
    // Code 3 on both fields
    randVals();
    sendFrame(2'd3, 2'd3, "R5 codes 3", -1, 1'b0, 2'd0, 2'd0);
    // Filler all ones then all zeros around the window
    randVals();
    sendFrame(2'd2, 2'd0, "R8 filler ones", 1, 1'b0, 2'd0, 2'd0);
    sendFrame(2'd1, 2'd0, "R8 filler zeros", 0, 1'b0, 2'd0, 2'd0);
    // Mid-frame change: old config holds for the whole frame
    randVals();
    sendFrame(2'd1, 2'd0, "R9 change mid frame", -1, 1'b1, 2'd2, 2'd2);
    randVals();
    sendFrame(2'd2, 2'd2, "R9 new config next frame", -1, 1'b0, 2'd0, 2'd0);

    // Constrained random frames
    for (int n = 0; n < 120; n++) begin
      logic [1:0] fc, lc;
      fc = 2'($urandom); lc = 2'($urandom);
      randVals();
      if (n % 7 == 3)
        sendFrame(fc, lc, "R9 random mid change", -1, 1'b1, 2'($urandom), 2'($urandom));
      else
        sendFrame(fc, lc, "R5 random frame", -1, 1'b0, 2'd0, 2'd0);
    end
    repeat (12) @(negedge clk);
    check("R10 all samples emitted", 64'(expData.size()), 64'(0));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule